// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block is a single-channel TDM PCM port. The bit clock also serves as the master clock. Once per frame it sends one 8-bit sample in a chosen transmit time slot and collects one 8-bit sample from a chosen receive time slot. The frame sync repeats at 8 kHz and may be a short pulse or a square wave. Its rising edge sets the nominal frame start for both directions. Each direction then shifts its own frame start later by 0 to 7 bit clocks.

The transmit line is released outside the transmit slot. The release is modelled by a drive-enable output. An active-low strobe tells a backplane line driver when the slot is live. Received bytes come out with a one-cycle valid pulse. If a slot number lies beyond the number of slots in the frame, that direction is switched off.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset, and until the first rising edge of `fsync`, `tx_oe` is 0, `slot_en_n` is 1 and `rx_valid` is 0.
- R2: With offset 0, frame bit 0 is the bit-clock period that follows the rising `clk` edge at which `fsync` is first sampled high. Frame bit k is the k-th period after that one.
- R3: For transmit slot N with offset D, `tx_oe` is 1 exactly during frame bits D+8N to D+8N+7. In those bits `tx_sd` carries the byte MSB first, one bit per period, changing after the rising `clk` edge. Whenever `tx_oe` is 0, `tx_sd` is 0.
- R4: `slot_en_n` is 0 exactly while `tx_oe` is 1. Otherwise it is 1 (released).
- R5: For receive slot M with offset E, `rx_sd` is sampled on the falling `clk` edge in frame bits E+8M to E+8M+7, MSB first. The byte appears on `rx_byte`, and `rx_valid` is 1 for one cycle starting at the rising edge that ends bit E+8M+7.
- R6: `tx_ofs` and `rx_ofs` (0 to 7 each) act independently of each other.
- R7: `rx_sd` outside the receive slot has no effect. `rx_byte` keeps its value and `rx_valid` stays 0.
- R8: A transmit slot number of SLOTS or more keeps `tx_oe` at 0 for the whole frame. A receive slot number of SLOTS or more produces no `rx_valid` and leaves `rx_byte` unchanged.
- R9: `tx_byte` is captured at the frame-start edge. Later changes to it do not reach the line until the next frame.
- R10: A square-wave `fsync` restarts the frame only on its rising edge. Holding `fsync` high or letting it fall has no effect.
- R11: A rising edge of `fsync` in the middle of a frame restarts bit counting from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, also the master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame sync, pulse or square wave |
| rx_sd | input | 1 | Serial receive data |
| tx_byte | input | 8 | Byte to transmit |
| tx_slot | input | SEL_W | Transmit slot number |
| rx_slot | input | SEL_W | Receive slot number |
| tx_ofs | input | 3 | Transmit frame-start delay in bit clocks |
| rx_ofs | input | 3 | Receive frame-start delay in bit clocks |
| tx_sd | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit drive enable (0 = high impedance) |
| slot_en_n | output | 1 | Active-low slot strobe for the line driver (1 = released) |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse marking a new `rx_byte` |

## Verification
The assertions check several behaviours on every cycle. They confirm silence before the first sync, and that the strobe is the complement of the drive enable. They confirm a quiet transmit line outside the slot and a drive run of no more than eight bits per frame. They also check that the valid strobe is a single-cycle pulse, that a disabled slot number produces no activity, and that the received byte holds between valid pulses. Only the bench scenarios can show bit positions against the sync edge, MSB-first order, the independent offsets, byte capture at frame start, and restarts on square-wave or mid-frame edges. The bench does this by comparing each line bit with the value expected for that frame bit.

// File: rtl/pcm_pkg.sv
// Shared types of the PCM slot port.
// Assumes: one byte per slot, bit index 0 is the MSB position on the line.
package pcm_pkg;

    typedef struct packed {
        logic       act;   // this bit clock lies inside the direction's slot
        logic [2:0] bidx;  // bit position within the slot, 0 = first (MSB)
    } slot_pos_t;

endpackage

// File: rtl/pcm_frame_timer.sv
// Frame timer: detects the rising edge of the frame sync and counts bit
// clocks from it. The count saturates at FMAX, which also serves as the
// idle value after reset.
// Assumes: fsync is synchronous to clk.
module pcm_frame_timer #(
    parameter int SLOTS = 32,
    parameter int FCW   = $clog2(8*SLOTS+9)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fsync,
    output logic           frame_start,
    output logic [FCW-1:0] fcnt
);
    localparam logic [FCW-1:0] FMAX = FCW'(8*SLOTS+8);

    logic fs_q;

    // Remember the previous fsync sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= 1'b0;
        else        fs_q <= fsync;
    end

    assign frame_start = fsync & ~fs_q;

    // Bit counter: cleared on a frame-start edge, saturating otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)            fcnt <= FMAX;
        else if (frame_start)  fcnt <= '0;
        else if (fcnt != FMAX) fcnt <= fcnt + 1'b1;
    end
endmodule

// File: rtl/pcm_slot_decode.sv
// Slot decoder for one direction. It subtracts the direction's delay from
// the frame count and reports whether the current bit clock falls in the
// selected slot, and at which bit.
// Assumes: slot numbers of SLOTS or more mean the direction is off.
module pcm_slot_decode
    import pcm_pkg::*;
#(
    parameter int SLOTS = 32,
    parameter int FCW   = $clog2(8*SLOTS+9),
    parameter int SEL_W = $clog2(SLOTS)+1
) (
    input  logic [FCW-1:0]   fcnt,
    input  logic [SEL_W-1:0] slot,
    input  logic [2:0]       ofs,
    output slot_pos_t        pos
);
    localparam int FBITS = 8*SLOTS;

    logic [FCW-1:0] rel;
    logic           in_frame;
    logic           slot_ok;

    // Position relative to this direction's delayed frame start.
    always_comb begin
        rel      = fcnt - FCW'(ofs);
        in_frame = (fcnt >= FCW'(ofs)) && (rel < FCW'(FBITS));
        slot_ok  = int'(slot) < SLOTS;
        pos.act  = in_frame && slot_ok && (int'(rel[FCW-1:3]) == int'(slot));
        pos.bidx = rel[2:0];
    end
endmodule

// File: rtl/pcm_rx_shift.sv
// Receive shifter. It samples the line on the falling clock edge, shifts the
// sample in on the next rising edge while in the slot, and emits the byte
// with a one-cycle valid pulse after the eighth bit.
// Assumes: pos describes the bit clock period that has just ended.
module pcm_rx_shift
    import pcm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_sd,
    input  slot_pos_t  pos,
    output logic [7:0] rx_byte,
    output logic       rx_valid
);
    logic       rx_smp;
    logic [6:0] shreg;

    // Mid-bit sample on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) rx_smp <= 1'b0;
        else        rx_smp <= rx_sd;
    end

    // Assemble the byte MSB first and pulse valid on its last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (pos.act) begin
                shreg <= {shreg[5:0], rx_smp};
                if (pos.bidx == 3'd7) begin
                    rx_byte  <= {shreg, rx_smp};
                    rx_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_slot_port.sv
// PCM time-slot serial port: one transmit and one receive byte per frame in
// programmable slots, each direction with its own 0..7 bit-clock delay.
// Assumes: clk is the bit clock; fsync, slot and offset inputs are
// synchronous to it; slot and offset settings stay stable within a frame.
module pcm_slot_port
    import pcm_pkg::*;
#(
    parameter  int SLOTS = 32,
    localparam int SEL_W = $clog2(SLOTS)+1,
    localparam int FCW   = $clog2(8*SLOTS+9)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic             rx_sd,
    input  logic [7:0]       tx_byte,
    input  logic [SEL_W-1:0] tx_slot,
    input  logic [SEL_W-1:0] rx_slot,
    input  logic [2:0]       tx_ofs,
    input  logic [2:0]       rx_ofs,
    output logic             tx_sd,
    output logic             tx_oe,
    output logic             slot_en_n,
    output logic [7:0]       rx_byte,
    output logic             rx_valid
);
    logic           frame_start;
    logic [FCW-1:0] fcnt;
    slot_pos_t      txp;
    slot_pos_t      rxp;
    logic [7:0]     tx_hold;

    pcm_frame_timer #(.SLOTS(SLOTS), .FCW(FCW)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .fsync       (fsync),
        .frame_start (frame_start),
        .fcnt        (fcnt)
    );

    pcm_slot_decode #(.SLOTS(SLOTS), .FCW(FCW), .SEL_W(SEL_W)) u_tx_dec (
        .fcnt (fcnt),
        .slot (tx_slot),
        .ofs  (tx_ofs),
        .pos  (txp)
    );

    pcm_slot_decode #(.SLOTS(SLOTS), .FCW(FCW), .SEL_W(SEL_W)) u_rx_dec (
        .fcnt (fcnt),
        .slot (rx_slot),
        .ofs  (rx_ofs),
        .pos  (rxp)
    );

    pcm_rx_shift u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_sd    (rx_sd),
        .pos      (rxp),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

    // Capture the outgoing byte at the frame-start edge.
    always_ff @(posedge clk) begin
        if (!rst_n)           tx_hold <= '0;
        else if (frame_start) tx_hold <= tx_byte;
    end

    // Line drive follows the registered frame count, so it changes on the rising edge.
    always_comb begin
        tx_oe     = txp.act;
        slot_en_n = ~txp.act;
        tx_sd     = txp.act & tx_hold[3'd7 - txp.bidx];
    end
endmodule

// File: rtl/pcm_slot_port_chk.sv
// Property checker for the PCM slot port, attached by bind.
// Assumes: the same SLOTS value as the bound instance.
module pcm_slot_port_chk #(
    parameter int SLOTS = 32,
    parameter int SEL_W = $clog2(SLOTS)+1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fsync,
    input logic [SEL_W-1:0] tx_slot,
    input logic [SEL_W-1:0] rx_slot,
    input logic             tx_sd,
    input logic             tx_oe,
    input logic             slot_en_n,
    input logic [7:0]       rx_byte,
    input logic             rx_valid
);
    logic       fs_prev;
    logic       seen;
    logic [3:0] run;

    // Track sync history and the length of the current drive run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_prev <= 1'b0;
            seen    <= 1'b0;
            run     <= '0;
        end else begin
            fs_prev <= fsync;
            if (fsync && !fs_prev) begin
                seen <= 1'b1;
                run  <= '0;
            end else if (tx_oe) begin
                if (run != 4'hF) run <= run + 1'b1;
            end else begin
                run <= '0;
            end
        end
    end

    p_idle_before_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> (!tx_oe && !rx_valid));
    p_slot_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run <= 4'd8);
    p_quiet_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> !tx_sd);
    p_strobe_pairs_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_oe != slot_en_n);
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    p_byte_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_byte));
    p_tx_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_slot) >= SLOTS) |-> !tx_oe);
    p_rx_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rx_slot) >= SLOTS) |=> !rx_valid);
endmodule

bind pcm_slot_port pcm_slot_port_chk #(.SLOTS(SLOTS), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fsync     (fsync),
    .tx_slot   (tx_slot),
    .rx_slot   (rx_slot),
    .tx_sd     (tx_sd),
    .tx_oe     (tx_oe),
    .slot_en_n (slot_en_n),
    .rx_byte   (rx_byte),
    .rx_valid  (rx_valid)
);

// File: tb/pcm_slot_port_test.sv
module pcm_slot_port_test;
    localparam int CLK_P = 10;
    localparam int SLOTS = 32;
    localparam int SW    = $clog2(SLOTS)+1;
    localparam int LEN   = 8*SLOTS+8;
    localparam int NV    = 8;

    typedef struct packed {
        logic [SW-1:0] ts;
        logic [SW-1:0] rs;
        logic [2:0]    to;
        logic [2:0]    ro;
        logic [7:0]    tb;
        logic [7:0]    rb;
        logic          sq;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{6'd0,  6'd0,  3'd0, 3'd0, 8'hA5, 8'h3C, 1'b0},
        '{6'd1,  6'd2,  3'd3, 3'd5, 8'h81, 8'h7E, 1'b0},
        '{6'd31, 6'd31, 3'd7, 3'd7, 8'hFF, 8'h01, 1'b0},
        '{6'd5,  6'd5,  3'd0, 3'd7, 8'h5A, 8'hC3, 1'b1},
        '{6'd32, 6'd10, 3'd1, 3'd2, 8'hFF, 8'h96, 1'b0},
        '{6'd12, 6'd40, 3'd4, 3'd0, 8'h0F, 8'h00, 1'b0},
        '{6'd7,  6'd3,  3'd6, 3'd1, 8'h00, 8'hFF, 1'b1},
        '{6'd20, 6'd20, 3'd2, 3'd6, 8'hC9, 8'h6D, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fsync = 1'b0;
    logic          rx_sd = 1'b0;
    logic [7:0]    tx_byte = '0;
    logic [SW-1:0] tx_slot = '0;
    logic [SW-1:0] rx_slot = '0;
    logic [2:0]    tx_ofs = '0;
    logic [2:0]    rx_ofs = '0;
    logic          tx_sd, tx_oe, slot_en_n, rx_valid;
    logic [7:0]    rx_byte;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] last_rx = '0;

    pcm_slot_port #(.SLOTS(SLOTS)) uut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .rx_sd(rx_sd),
        .tx_byte(tx_byte), .tx_slot(tx_slot), .rx_slot(rx_slot),
        .tx_ofs(tx_ofs), .rx_ofs(rx_ofs), .tx_sd(tx_sd), .tx_oe(tx_oe),
        .slot_en_n(slot_en_n), .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // One frame: sync edge, then per-bit checks of the line and the receive result (R2, R3, R4, R5, R6, R7, R8, R9, R10).
    task automatic run_frame(input vec_t v, input bit chg);
        int tstart = int'(v.to) + 8*int'(v.ts);
        int rstart = int'(v.ro) + 8*int'(v.rs);
        bit ten = int'(v.ts) < SLOTS;
        bit ren = int'(v.rs) < SLOTS;
        @(posedge clk); #2;
        tx_slot = v.ts; rx_slot = v.rs; tx_ofs = v.to; rx_ofs = v.ro;
        tx_byte = v.tb; fsync = 1'b1;
        for (int i = 0; i <= LEN; i++) begin
            bit eoe, esd, eval;
            @(posedge clk); #2;
            if (!v.sq && i == 0) fsync = 1'b0;
            if (v.sq && i == LEN/2) fsync = 1'b0;
            if (chg && i == 0) tx_byte = ~v.tb;
            eoe  = ten && i >= tstart && i < tstart + 8;
            esd  = eoe ? v.tb[7 - (i - tstart)] : 1'b0;
            eval = ren && i == rstart + 8;
            chk(tx_oe == eoe, "R3 tx_oe", int'(tx_oe), int'(eoe));
            chk(tx_sd == esd, "R3/R9 tx_sd", int'(tx_sd), int'(esd));
            chk(slot_en_n == !eoe, "R4 slot_en_n", int'(slot_en_n), int'(!eoe));
            chk(rx_valid == eval, "R5/R8 rx_valid", int'(rx_valid), int'(eval));
            if (eval) begin
                chk(rx_byte == v.rb, "R5 rx_byte", int'(rx_byte), int'(v.rb));
                last_rx = v.rb;
            end
            if (ren && i >= rstart && i < rstart + 8) rx_sd = v.rb[7 - (i - rstart)];
            else                                      rx_sd = i[0] ^ i[2]; // noise, R7
        end
        chk(rx_byte == last_rx, "R7/R8 rx_byte held", int'(rx_byte), int'(last_rx));
    endtask

    initial begin
        #(CLK_P*200000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state, and silence until the first sync edge
        repeat (3) @(posedge clk);
        #2;
        chk(tx_oe == 1'b0 && slot_en_n == 1'b1 && rx_valid == 1'b0, "R1 reset",
            int'({tx_oe, slot_en_n, rx_valid}), 3'b010);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #2;
            rx_sd = i[0];
            chk(!tx_oe && slot_en_n && !rx_valid, "R1 idle", int'({tx_oe, slot_en_n, rx_valid}), 3'b010);
        end
        // Table of frames: R2, R3, R5, R6, R8 (disabled slots), R10 (square-wave sync)
        for (int k = 0; k < NV; k++) run_frame(VECS[k], 1'b0);
        // R9: change tx_byte after the frame edge; the captured byte goes out
        run_frame('{6'd2, 6'd1, 3'd1, 3'd4, 8'h3B, 8'hE4, 1'b0}, 1'b1);
        // R11: sync edge, abort after 3 bits with a new edge; timing follows the new edge
        @(posedge clk); #2;
        tx_slot = 6'd0; tx_ofs = 3'd2; rx_slot = 6'd0; rx_ofs = 3'd0; fsync = 1'b1;
        @(posedge clk); #2;
        fsync = 1'b0;
        repeat (3) begin @(posedge clk); #2; rx_sd = 1'b1; end
        run_frame('{6'd0, 6'd0, 3'd2, 3'd0, 8'h6A, 8'h52, 1'b0}, 1'b0);
        summary();
        $finish;
    end
endmodule